// File: doc/BRIEF.md
# Thermal voltage level governor

This block sets the chip's operating voltage level from a thermal reading. On a programmable sampling interval it compares the hottest on-die temperature against a programmable critical threshold. It then moves a discrete voltage level by one step: down when the die is too hot, up when it is not. Each level has a fixed pair of codes, a voltage code and a base clock frequency code. Both codes are driven out for the regulator and the clock generator, and the frequency always follows the level it belongs to.

The sampling interval is counted in enabled cycles, marked by a one-cycle strobe. An evaluation fires on the strobe once more strobes have passed since the previous evaluation than the programmed interval, so an interval of N gives one evaluation every N+1 strobes. Each level change produces a one-cycle pulse, which a downstream stall or penalty counter can use.

When the die is still too hot at the lowest level, no lower level exists. The block then raises a sticky panic flag and holds the level. The flag clears at the next evaluation that finds the die at or below the threshold.

Top module: `thermal_vgov`

## Requirements
- R1: An evaluation occurs only in a cycle with `tick`=1 in which the number of earlier ticks since the previous evaluation (or since reset) is at least `interval`. Every evaluation restarts that count from zero, and the level and panic flag change only on an evaluation.
- R2: On an evaluation with `temp_max` strictly greater than `temp_crit` and `level` above 0, `level` decreases by one. A temperature equal to the threshold does not count as hot.
- R3: On an evaluation with `temp_max` > `temp_crit` and `level` = 0, `panic` is set to 1 and `level` stays at 0.
- R4: On an evaluation with `temp_max` <= `temp_crit` and `level` below the top level, `level` increases by one.
- R5: At the top level (7 with 8 levels) `at_max` is 1, and it is 0 at every other level. An evaluation that is not hot leaves the level at the top and gives no `changed` pulse.
- R6: `volt_code` equals 60 + 10·level and `freq_code` equals 40 + 20·level at all times. Both codes therefore change together with `level`.
- R7: `changed` is 1 for exactly the one cycle after each clock edge at which the level changed, and 0 otherwise.
- R8: Once set, `panic` stays 1 until an evaluation finds `temp_max` <= `temp_crit`, which clears it.
- R9: After reset, `level` is 7, `volt_code` is 130, `freq_code` is 180, `at_max` is 1, and both `panic` and `changed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Cycle-enable strobe that advances the interval count |
| temp_max | input | 8 | Hottest temperature among all monitored units, unsigned |
| temp_crit | input | 8 | Critical threshold, unsigned |
| interval | input | 8 | Number of ticks that must pass between evaluations |
| level | output | 3 | Current voltage level index |
| volt_code | output | 8 | Voltage code paired with the level |
| freq_code | output | 8 | Base frequency code paired with the level |
| changed | output | 1 | One-cycle pulse after a level change |
| panic | output | 1 | Sticky flag: too hot at the lowest level |
| at_max | output | 1 | Level is at the top |

## Verification
The bench builds the block with its default parameters: eight levels and 8-bit temperature, interval and codes. It programs intervals between 0 and 5 only, so evaluations come every few ticks and random runs cross the whole level range many times. Both the saturating top and the panic floor are reached within a few hundred cycles. Temperatures are drawn close to the threshold, including exact equality. Directed sequences cover gaps in the tick strobe and an interval lowered below the running count.

// File: rtl/tvg_pkg.sv
package tvg_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_DOWN  = 2'd1,
        ACT_UP    = 2'd2,
        ACT_PANIC = 2'd3
    } tvg_act_e;

    // Linear per-level code: base plus step times level index
    function automatic int unsigned tvg_code(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/tvg_interval_timer.sv
module tvg_interval_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] interval,
    output logic          eval
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        eval  = 1'b0;
        if (tick) begin
            if (tmr_q.cnt >= interval) begin
                eval      = 1'b1;
                tmr_d.cnt = '0;
            end else if (tmr_q.cnt != CNT_MAX) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R1: every evaluation restarts the count
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (tmr_q.cnt == '0));

    // R1: without a tick the count is frozen
    a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tmr_q.cnt));

endmodule

// File: rtl/tvg_level_step.sv
module tvg_level_step
    import tvg_pkg::*;
#(
    parameter int NLEV = 8,
    parameter int LW   = 3,
    parameter int TW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval,
    input  logic [TW-1:0] temp_max,
    input  logic [TW-1:0] temp_crit,
    output logic [LW-1:0] level,
    output logic          panic,
    output logic          changed,
    output logic          at_max
);
    localparam logic [LW-1:0] TOP = LW'(NLEV - 1);

    typedef struct packed {
        logic [LW-1:0] level;
        logic          panic;
        logic          changed;
    } st_t;

    st_t      st_d, st_q;
    tvg_act_e act;
    logic     hot;

    assign hot = (temp_max > temp_crit);

    always_comb begin
        act = ACT_HOLD;
        if (eval) begin
            if (hot) begin
                act = (st_q.level != '0) ? ACT_DOWN : ACT_PANIC;
            end else if (st_q.level != TOP) begin
                act = ACT_UP;
            end
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.changed = 1'b0;
        if (eval && !hot) begin
            st_d.panic = 1'b0;
        end
        unique case (act)
            ACT_DOWN: begin
                st_d.level   = st_q.level - 1'b1;
                st_d.changed = 1'b1;
            end
            ACT_UP: begin
                st_d.level   = st_q.level + 1'b1;
                st_d.changed = 1'b1;
            end
            ACT_PANIC: begin
                st_d.panic = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level   <= TOP;
            st_q.panic   <= 1'b0;
            st_q.changed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level   = st_q.level;
    assign panic   = st_q.panic;
    assign changed = st_q.changed;
    assign at_max  = (st_q.level == TOP);

    // R1: the level and the panic flag only move on an evaluation
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> ($stable(st_q.level) && $stable(st_q.panic)));

    // R2: a hot evaluation above the floor steps down
    a_r2_down: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && hot && st_q.level != '0) |=> (st_q.level == $past(st_q.level) - 1'b1));

    // R3: a hot evaluation at the floor raises panic and holds
    a_r3_floor_panic: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && hot && st_q.level == '0) |=> (st_q.panic && st_q.level == '0));

    // R4: a cool evaluation below the top steps up
    a_r4_up: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !hot && st_q.level != TOP) |=> (st_q.level == $past(st_q.level) + 1'b1));

    // R5: saturation at the top
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !hot && at_max) |=> (at_max && !changed));

    // R7: the pulse marks exactly the edges where the level moved
    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (changed == (st_q.level != $past(st_q.level))));

    // R8: a cool evaluation clears panic
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !hot) |=> !st_q.panic);

endmodule

// File: rtl/tvg_code_table.sv
module tvg_code_table
    import tvg_pkg::*;
#(
    parameter int NLEV   = 8,
    parameter int LW     = 3,
    parameter int VW     = 8,
    parameter int FW     = 8,
    parameter int V_BASE = 60,
    parameter int V_STEP = 10,
    parameter int F_BASE = 40,
    parameter int F_STEP = 20
) (
    input  logic [LW-1:0] idx,
    output logic [VW-1:0] volt,
    output logic [FW-1:0] freq
);
    logic [VW-1:0] vtab [NLEV];
    logic [FW-1:0] ftab [NLEV];

    for (genvar g = 0; g < NLEV; g++) begin : g_entry
        assign vtab[g] = VW'(tvg_code(V_BASE, V_STEP, g));
        assign ftab[g] = FW'(tvg_code(F_BASE, F_STEP, g));
    end

    always_comb begin
        volt = vtab[0];
        freq = ftab[0];
        for (int i = 0; i < NLEV; i++) begin
            if (idx == LW'(i)) begin
                volt = vtab[i];
                freq = ftab[i];
            end
        end
    end

endmodule

// File: rtl/thermal_vgov.sv
module thermal_vgov #(
    parameter int NLEV   = 8,
    parameter int TW     = 8,
    parameter int CW     = 8,
    parameter int VW     = 8,
    parameter int FW     = 8,
    parameter int V_BASE = 60,
    parameter int V_STEP = 10,
    parameter int F_BASE = 40,
    parameter int F_STEP = 20,
    localparam int LW    = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] temp_max,
    input  logic [TW-1:0] temp_crit,
    input  logic [CW-1:0] interval,
    output logic [LW-1:0] level,
    output logic [VW-1:0] volt_code,
    output logic [FW-1:0] freq_code,
    output logic          changed,
    output logic          panic,
    output logic          at_max
);
    logic eval;

    tvg_interval_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .interval (interval),
        .eval     (eval)
    );

    tvg_level_step #(.NLEV(NLEV), .LW(LW), .TW(TW)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (eval),
        .temp_max  (temp_max),
        .temp_crit (temp_crit),
        .level     (level),
        .panic     (panic),
        .changed   (changed),
        .at_max    (at_max)
    );

    tvg_code_table #(
        .NLEV(NLEV), .LW(LW), .VW(VW), .FW(FW),
        .V_BASE(V_BASE), .V_STEP(V_STEP), .F_BASE(F_BASE), .F_STEP(F_STEP)
    ) u_table (
        .idx  (level),
        .volt (volt_code),
        .freq (freq_code)
    );

    // R6: codes move only together with a level change pulse
    a_r6_codes_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !changed |-> ($stable(freq_code) && $stable(volt_code)));

    // R6: a change pulse always comes with a new frequency code
    a_r6_codes_follow: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> (freq_code != $past(freq_code)));

endmodule

// File: tb/sim_thermal_vgov.sv
`timescale 1ns/1ps
module sim_thermal_vgov;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] temp_max = 8'd0;
    logic [7:0] temp_crit = 8'd100;
    logic [7:0] interval = 8'd0;
    logic [2:0] level;
    logic [7:0] volt_code, freq_code;
    logic       changed, panic, at_max;

    int checks = 0;
    int failures = 0;

    // bench model state
    int m_cnt = 0;
    int m_lvl = 7;
    bit m_panic = 0;
    bit m_chg = 0;

    always #2.5 clk = ~clk;

    thermal_vgov u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .temp_max(temp_max),
        .temp_crit(temp_crit), .interval(interval), .level(level),
        .volt_code(volt_code), .freq_code(freq_code), .changed(changed),
        .panic(panic), .at_max(at_max)
    );

    function automatic int exp_volt(input int l); return 60 + 10 * l; endfunction
    function automatic int exp_freq(input int l); return 40 + 20 * l; endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(level == 3'(m_lvl), "R2/R4 level", level, m_lvl);
        chk(panic == m_panic, "R3/R8 panic", panic, m_panic);
        chk(changed == m_chg, "R7 changed", changed, m_chg);
        chk(at_max == (m_lvl == 7), "R5 at_max", at_max, m_lvl == 7);
        chk(volt_code == 8'(exp_volt(m_lvl)), "R6 volt_code", volt_code, exp_volt(m_lvl));
        chk(freq_code == 8'(exp_freq(m_lvl)), "R6 freq_code", freq_code, exp_freq(m_lvl));
    endtask

    // Called at a negedge: drive, advance model across the posedge, check at next negedge
    task automatic step(input bit t, input int tm, input int tc, input int iv);
        bit ev, hot;
        tick = t; temp_max = 8'(tm); temp_crit = 8'(tc); interval = 8'(iv);
        @(posedge clk);
        hot = (tm > tc);
        ev = t && (m_cnt >= iv);
        m_chg = 0;
        if (t) m_cnt = ev ? 0 : ((m_cnt < 255) ? m_cnt + 1 : m_cnt);
        if (ev) begin
            if (hot) begin
                if (m_lvl > 0) begin m_lvl--; m_chg = 1; end
                else m_panic = 1;
            end else begin
                m_panic = 0;
                if (m_lvl < 7) begin m_lvl++; m_chg = 1; end
            end
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        #900000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(level == 3'd7, "R9 reset level", level, 7);
        chk(volt_code == 8'd130, "R9 reset volt", volt_code, 130);
        chk(freq_code == 8'd180, "R9 reset freq", freq_code, 180);
        chk(at_max && !panic && !changed, "R9 reset flags", {at_max, panic, changed}, 3'b100);

        // R1: interval 3, hot: three ticks hold, fourth steps down
        for (int i = 0; i < 3; i++) begin
            step(1, 150, 100, 3);
            chk(level == 3'd7, "R1 no early step", level, 7);
        end
        step(1, 150, 100, 3);
        chk(level == 3'd6 && changed, "R2 step down after interval", level, 6);
        // R7: pulse gone one cycle later with no tick
        step(0, 150, 100, 3);
        chk(!changed, "R7 single cycle pulse", changed, 0);
        // R1: tick gaps do not advance the count
        for (int i = 0; i < 6; i++) step(i % 2, 150, 100, 2);
        chk(level == 3'd5, "R1 ticks only count", level, 5);
        // R2: equal temperature is not hot -> up
        for (int i = 0; i < 3; i++) step(1, 100, 100, 2);
        chk(level == 3'd6, "R2 equality counts as cool", level, 6);
        // R1: lowering interval below running count fires next tick
        step(1, 200, 100, 9);
        step(1, 200, 100, 9);
        step(1, 200, 100, 0);
        chk(level == 3'd5, "R1 lowered interval fires", level, 5);
        // R3: drive to floor, then panic
        for (int i = 0; i < 5; i++) step(1, 255, 0, 0);
        chk(level == 3'd0 && !panic, "R2 reach floor", level, 0);
        step(1, 255, 0, 0);
        chk(panic && level == 3'd0 && !changed, "R3 panic at floor", panic, 1);
        // R8: panic sticky without evaluation
        for (int i = 0; i < 4; i++) step(0, 0, 255, 0);
        chk(panic, "R8 panic sticky", panic, 1);
        step(1, 10, 20, 0);
        chk(!panic && level == 3'd1, "R8 cool clears panic", panic, 0);
        // R5: climb to top and saturate
        for (int i = 0; i < 8; i++) step(1, 0, 50, 0);
        chk(level == 3'd7 && at_max && !changed, "R5 saturate at top", level, 7);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int tc, tm;
            tc = 100;
            tm = 90 + int'($urandom_range(0, 20));
            step(bit'($urandom_range(0, 3) != 0), tm, tc, int'($urandom_range(0, 5)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule